// File: doc/BRIEF.md
# Change-Triggered Unit Delay Register

This block is a clocked delay element that counts input changes, not clock cycles. It samples an n-bit input vector on every clock edge. Each time the sampled vector differs from the value it currently holds, it moves that held value to its output and keeps the new vector as its present value. The output therefore always shows the vector the input had just before its latest change. That stays true however long the input rests at any one value.

A parameter selects how the input may move. In any-change mode every new vector is accepted, even when several bits flip together. In adjacent-change mode only a one-bit step is legal. A step of two or more bits raises a one-cycle violation pulse and leaves the output as it was. The block also adopts the new vector as its present value, so it does not keep flagging the same step. A one-cycle strobe marks every cycle in which the output takes a new value, so downstream logic can follow change events.

The input first passes through a two-flop synchronizer. Reset loads the synchronizer, the present-value register and the output register with one common vector, so the block starts with nothing pending.

Top module: `chg_delay_reg`

## Requirements
- R1: While `rst_ni` is low, and at the first clock edge after it rises, `data_o` equals `RST_VAL` (zero by default), and `changed_o` and `viol_o` are 0.
- R2: While the input vector stays constant, `data_o` does not change, for any number of cycles.
- R3: When `data_i` changes to a new vector and a legal change is accepted, `data_o` takes the vector the input held before that change. This happens on the third rising clock edge after the new vector is first sampled: two synchronizer edges, then the update edge.
- R4: `changed_o` is 1 for exactly the cycle in which `data_o` shows a newly accepted value, and 0 in every other cycle. `data_o` never changes while `changed_o` is 0.
- R5: With `MODE` = `CHG_ANY` (encoding 0), a change of any number of bits, including all bits at once, is accepted, and `viol_o` stays 0 at all times.
- R6: With `MODE` = `CHG_ADJACENT` (encoding 1), a change of two or more bits raises `viol_o` for one cycle, with `changed_o` at 0 and `data_o` unchanged. The new vector becomes the present value, so a later legal change outputs it.
- R7: With `MODE` = `CHG_ADJACENT`, a change of exactly one bit behaves as in R3 and R4. The new output then differs in exactly one bit from the present value.
- R8: Input vectors that are each held for at least one clock cycle are each seen as a separate change, so back-to-back one-cycle values yield back-to-back output updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | WIDTH | Input vector, asynchronous to the clock |
| data_o | output | WIDTH | Vector held before the latest accepted change |
| changed_o | output | 1 | One-cycle strobe when `data_o` updates |
| viol_o | output | 1 | One-cycle pulse on a multi-bit step in adjacent mode |

## Verification
The same input stream drives two instances, one in each mode. That lets one stimulus separate accepted multi-bit steps from flagged ones. Directed parts cover a long hold, which shows that clock count alone does not move the output. They also cover an A-B-A return, which shows that the output tracks order and not value, and a flip of every bit at once. A run of one-cycle values checks that changes packed closely are still each counted. A seeded random stream then mixes one-bit flips with arbitrary vectors and holds of varying length. The bench compares every cycle against a change-counting model, with the three-edge latency applied.

// File: rtl/chg_delay_pkg.sv
package chg_delay_pkg;
  typedef enum logic {
    CHG_ANY      = 1'b0,
    CHG_ADJACENT = 1'b1
  } chg_mode_e;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chg_detect.sv
module chg_detect
  import chg_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter chg_mode_e   MODE  = CHG_ANY
) (
  input  logic [WIDTH-1:0] smp_i,
  input  logic [WIDTH-1:0] cur_i,
  output logic             diff_o,
  output logic             legal_o
);
  logic [WIDTH-1:0] delta;
  assign delta  = smp_i ^ cur_i;
  assign diff_o = |delta;

  if (MODE == CHG_ADJACENT) begin : g_adj
    // single set bit: x & (x-1) == 0
    assign legal_o = ((delta & (delta - WIDTH'(1))) == '0);
  end else begin : g_any
    assign legal_o = 1'b1;
  end
endmodule

// File: rtl/chg_hold.sv
module chg_hold #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] smp_i,
  input  logic             diff_i,
  input  logic             legal_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] out_o,
  output logic             changed_o,
  output logic             viol_o
);
  logic [WIDTH-1:0] cur_q, out_q;
  logic             chg_q, viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= RST_VAL;
      out_q  <= RST_VAL;
      chg_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      chg_q  <= 1'b0;
      viol_q <= 1'b0;
      if (diff_i) begin
        cur_q <= smp_i;
        if (legal_i) begin
          out_q <= cur_q;
          chg_q <= 1'b1;
        end else begin
          viol_q <= 1'b1;
        end
      end
    end
  end

  assign cur_o     = cur_q;
  assign out_o     = out_q;
  assign changed_o = chg_q;
  assign viol_o    = viol_q;
endmodule

// File: rtl/chg_delay_reg.sv
module chg_delay_reg
  import chg_delay_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter chg_mode_e   MODE        = CHG_ANY,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             changed_o,
  output logic             viol_o
);
  logic [WIDTH-1:0] smp_w, cur_w;
  logic             diff_w, legal_w;

  chg_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(smp_w)
  );

  chg_detect #(.WIDTH(WIDTH), .MODE(MODE)) u_detect (
    .smp_i(smp_w), .cur_i(cur_w), .diff_o(diff_w), .legal_o(legal_w)
  );

  chg_hold #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_hold (
    .clk_i, .rst_ni, .smp_i(smp_w), .diff_i(diff_w), .legal_i(legal_w),
    .cur_o(cur_w), .out_o(data_o), .changed_o, .viol_o
  );
endmodule

// File: rtl/chg_delay_reg_chk.sv
module chg_delay_reg_chk
  import chg_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter chg_mode_e   MODE  = CHG_ANY
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] data_o,
  input logic             changed_o,
  input logic             viol_o,
  input logic [WIDTH-1:0] cur_q
);
  assert_out_moves_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> changed_o);

  assert_no_dual_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(changed_o && viol_o));

  assert_out_differs_cur_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> (data_o != cur_q));

  assert_viol_keeps_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $stable(data_o));

  if (MODE == CHG_ANY) begin : g_any
    assert_no_viol_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !viol_o);
  end else begin : g_adj
    assert_one_bit_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      changed_o |-> ($countones(data_o ^ cur_q) == 1));
  end
endmodule

bind chg_delay_reg chg_delay_reg_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
  .clk_i, .rst_ni, .data_o, .changed_o, .viol_o, .cur_q(cur_w)
);

// File: tb/chg_delay_reg_tb.sv
module chg_delay_reg_tb;
  import chg_delay_pkg::*;
  localparam int W = 4;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q_a, q_s;
  logic ch_a, ch_s, vi_a, vi_s;
  int errors = 0, checks = 0;
  bit done = 0, live = 0;

  always #2.5 clk = ~clk;

  chg_delay_reg #(.WIDTH(W), .MODE(CHG_ANY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .data_o(q_a), .changed_o(ch_a), .viol_o(vi_a));
  chg_delay_reg #(.WIDTH(W), .MODE(CHG_ADJACENT)) u_dut_single (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .data_o(q_s), .changed_o(ch_s), .viol_o(vi_s));

  // model state: three-cycle sight delay, then change counting
  logic [W-1:0] d0 = '0, d1 = '0, d2 = '0;
  logic [W-1:0] a_cur = '0, a_out = '0, s_cur = '0, s_out = '0;

  function automatic bit one_bit(input logic [W-1:0] x);
    return (x != '0) && ((x & (x - 1'b1)) == '0);
  endfunction

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 reset any", {q_a, ch_a, vi_a}, '0);
      chk("R1 reset adj", {q_s, ch_s, vi_s}, '0);
    end else if (live) begin
      logic ea_chg, es_chg, es_viol;
      ea_chg = (d2 != a_cur);
      if (ea_chg) begin a_out = a_cur; a_cur = d2; end
      es_chg = 0; es_viol = 0;
      if (d2 != s_cur) begin
        if (one_bit(d2 ^ s_cur)) begin es_chg = 1; s_out = s_cur; end
        else es_viol = 1;
        s_cur = d2;
      end
      chk(ea_chg ? "R3/R4/R5 any change" : "R2/R4 any hold", {q_a, ch_a, vi_a}, {a_out, ea_chg, 1'b0});
      chk(es_viol ? "R6 adj violation" : (es_chg ? "R7/R4 adj step" : "R2 adj hold"),
          {q_s, ch_s, vi_s}, {s_out, es_chg, es_viol});
      d2 = d1; d1 = d0; d0 = din;
    end
  end

  task automatic put(input logic [W-1:0] v, input int hold);
    @(posedge clk); #1 din = v;
    repeat (hold - 1) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    repeat (3) @(posedge clk);
    put(4'h1, 60);   // R3 single-bit, then long hold R2
    put(4'h3, 8);    // R7
    put(4'h1, 8);    // R3 A-B-A order
    put(4'hE, 8);    // R5 all bits, R6 in adjacent
    put(4'hF, 8);    // R6 next legal step outputs adopted value
    put(4'h7, 1);    // R8 back-to-back
    put(4'h6, 1);
    put(4'h4, 1);
    put(4'h5, 6);
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] nv;
      if ($urandom_range(1, 0) == 1) nv = din ^ (W'(1) << $urandom_range(W - 1, 0));
      else nv = W'($urandom);
      put(nv, int'($urandom_range(6, 1)));
    end
    repeat (6) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule